// File: doc/BRIEF.md
# Mixed-Sign Multiply-Accumulate Unit

This block is the multiply/accumulate stage of a fixed-point DSP datapath. It holds two X operand registers and two Y operand registers. Each cycle it multiplies one chosen X operand by one chosen Y operand, and it can treat either operand as signed or unsigned. The product either replaces a 40-bit accumulator or is added to it or subtracted from it. The accumulator is made of a 16-bit low word, a 16-bit high word and an 8-bit guard byte, so a long run of sums can exceed the 32-bit range without losing data.

A result goes either to the main 40-bit result register or to a 16-bit feedback register. The feedback register captures the high word of the result. The high word of the result register and the feedback register can both be selected as operands for the next operation. Operand registers can be reloaded in the same cycle as a computation, so a new multiply/accumulate can start every cycle. Convergent (round-half-to-even) rounding at bit 15 is optional and happens in the same cycle. A registered flag reports when a result has left the signed 32-bit range.

Top module: `mac_unit`

## Requirements
- R1: Any X operand register (select code 0 = register 0, 1 = register 1) can be paired with any Y operand register, using the same codes.
- R2: Each operand is independently treated as signed two's complement when its sign input is 1, and as unsigned when it is 0.
- R3: The op code selects the operation: 2'b00 holds the result register, feedback register and flag unchanged; 2'b01 stores the product; 2'b10 adds the product to the result register; 2'b11 subtracts the product from the result register.
- R4: The product is sign-extended to 40 bits and the sum is kept at 40 bits, so a sum beyond the 32-bit range is held exactly and can be brought back by later operations.
- R5: On every non-hold operation, the overflow flag is set to 1 when bits 39:31 of the new result are not all equal, and cleared otherwise.
- R6: With the destination input at 1, the feedback register takes bits 31:16 of the result and the result register is unchanged. With it at 0, the result register takes the result and the feedback register is unchanged.
- R7: Operand select code 2 chooses bits 31:16 of the result register and code 3 chooses the feedback register, for both X and Y.
- R8: A write to an operand register takes effect at the clock edge, so an operation issued in the same cycle uses the old value. A write changes only the addressed register.
- R9: With rounding enabled, 0x8000 is added to the result before it is stored. If the low 16 bits before rounding are exactly 0x8000, bit 16 of the rounded value is cleared, so ties round to even.
- R10: A synchronous active-high reset clears all operand registers, the result register, the feedback register and the flag.
- R11: Each operation's result is visible at the outputs right after the clock edge on which it was issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xw_en | input | 1 | Write enable for an X operand register |
| xw_idx | input | 1 | X register to write |
| xw_data | input | 16 | X write data |
| yw_en | input | 1 | Write enable for a Y operand register |
| yw_idx | input | 1 | Y register to write |
| yw_data | input | 16 | Y write data |
| op | input | 2 | Operation code (R3) |
| x_src | input | 2 | X operand select (R1, R7) |
| y_src | input | 2 | Y operand select (R1, R7) |
| x_sgn | input | 1 | X operand is signed |
| y_sgn | input | 1 | Y operand is signed |
| rnd_en | input | 1 | Enable convergent rounding |
| to_fb | input | 1 | Send the result to the feedback register |
| acc_o | output | 40 | Result register |
| fb_o | output | 16 | Feedback register |
| ovf_o | output | 1 | Result left the 32-bit range |

## Verification
The bench builds the block with its default parameters: 16-bit operands and an 8-bit guard byte. These sizes make the signed extremes reachable in a few cycles. Four products of -32768 by -32768 carry the accumulator past 2^32 into the guard byte, and four subtractions bring it back. The same sizes expose the bit-15 tie case directly. A reference model built on plain integers is compared against every output on every clock, under directed and random sequences.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'b00,
    OP_LOAD = 2'b01,
    OP_ADD  = 2'b10,
    OP_SUB  = 2'b11
  } mac_op_e;

  typedef enum logic [1:0] {
    SRC_REG0 = 2'b00,
    SRC_REG1 = 2'b01,
    SRC_ACC  = 2'b10,
    SRC_FB   = 2'b11
  } opnd_src_e;
endpackage

// File: rtl/mac_operand_bank.sv
module mac_operand_bank #(
  parameter int DW = 16,
  parameter int NREG = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    src,
  input  logic [DW-1:0] acc_hi,
  input  logic [DW-1:0] fb,
  output logic [DW-1:0] opnd
);
  import mac_pkg::*;

  logic [DW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs_q[g] <= '0;
      end else if (wr_en && (int'(wr_idx) == g)) begin
        regs_q[g] <= wr_data;
      end
    end
  end

  always_comb begin
    unique case (opnd_src_e'(src))
      SRC_REG0: opnd = regs_q[0];
      SRC_REG1: opnd = regs_q[1];
      SRC_ACC:  opnd = acc_hi;
      default:  opnd = fb;
    endcase
  end

  // R8: writing one register leaves the other untouched
  p_write_isolated_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_idx) |=> $stable(regs_q[1]));
  p_write_isolated1_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx) |=> $stable(regs_q[0]));
  // R8: idle bank keeps both registers
  p_no_write_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(regs_q[0]) && $stable(regs_q[1])));
endmodule

// File: rtl/mac_multiplier.sv
module mac_multiplier #(
  parameter int DW = 16,
  localparam int PW = 2 * DW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DW-1:0]        a,
  input  logic [DW-1:0]        b,
  input  logic                 a_sgn,
  input  logic                 b_sgn,
  output logic signed [PW-1:0] prod
);
  logic signed [DW:0] a_ext;
  logic signed [DW:0] b_ext;

  assign a_ext = {a_sgn & a[DW-1], a};
  assign b_ext = {b_sgn & b[DW-1], b};
  assign prod  = PW'(a_ext) * PW'(b_ext);

  // R2: a product of two unsigned operands is never negative
  always_comb begin
    if (!rst && !a_sgn && !b_sgn) begin
      p_unsigned_nonneg_r2: assert (prod[PW-1] == 1'b0);
    end
  end

  // R2: a zero operand gives a zero product whatever the signs
  p_zero_operand_r2: assert property (@(posedge clk) disable iff (rst)
    ((a == '0) || (b == '0)) |-> (prod == '0));
endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
  parameter int DW = 16,
  parameter int GW = 8,
  localparam int PW = 2 * DW + 2,
  localparam int AW = 2 * DW + GW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           op,
  input  logic signed [PW-1:0] prod,
  input  logic                 rnd_en,
  input  logic                 to_fb,
  output logic [AW-1:0]        acc_o,
  output logic [DW-1:0]        fb_o,
  output logic                 ovf_o
);
  import mac_pkg::*;

  localparam logic [AW-1:0] HALF = AW'(1) << (DW - 1);
  localparam logic [DW-1:0] TIE  = {1'b1, {(DW - 1){1'b0}}};

  logic [AW-1:0] acc_q;
  logic [DW-1:0] fb_q;
  logic          ovf_q;
  logic [AW-1:0] prod_x;
  logic [AW-1:0] sum;
  logic [AW-1:0] res;
  logic [AW-2*DW:0] top_bits;
  logic          ovf_n;
  mac_op_e       op_e;

  assign op_e   = mac_op_e'(op);
  assign prod_x = {{(AW - PW){prod[PW-1]}}, prod};

  always_comb begin
    unique case (op_e)
      OP_ADD:  sum = acc_q + prod_x;
      OP_SUB:  sum = acc_q - prod_x;
      default: sum = prod_x;
    endcase
    res = sum;
    if (rnd_en) begin
      res = sum + HALF;
      if (sum[DW-1:0] == TIE) res[DW] = 1'b0;
    end
    top_bits = res[AW-1:2*DW-1];
    ovf_n    = !((&top_bits) || !(|top_bits));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      fb_q  <= '0;
      ovf_q <= 1'b0;
    end else if (op_e != OP_HOLD) begin
      ovf_q <= ovf_n;
      if (to_fb) fb_q  <= res[2*DW-1:DW];
      else       acc_q <= res;
    end
  end

  assign acc_o = acc_q;
  assign fb_o  = fb_q;
  assign ovf_o = ovf_q;

  // R3: hold keeps all results
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (op_e == OP_HOLD) |=> ($stable(acc_q) && $stable(fb_q) && $stable(ovf_q)));
  // R3: unrounded load stores the extended product
  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    (op_e == OP_LOAD && !rnd_en && !to_fb) |=> (acc_q == $past(prod_x)));
  // R6: feedback destination leaves the result register alone
  p_fb_dest_r6: assert property (@(posedge clk) disable iff (rst)
    (op_e != OP_HOLD && to_fb) |=> $stable(acc_q));
  p_acc_dest_r6: assert property (@(posedge clk) disable iff (rst)
    (op_e != OP_HOLD && !to_fb) |=> $stable(fb_q));
  // R5: flag agrees with the stored result
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    (op_e != OP_HOLD && !to_fb) |=>
      (ovf_q == !((&acc_q[AW-1:2*DW-1]) || !(|acc_q[AW-1:2*DW-1]))));
endmodule

// File: rtl/mac_unit.sv
module mac_unit #(
  parameter int DW = 16,
  parameter int GW = 8,
  localparam int PW = 2 * DW + 2,
  localparam int AW = 2 * DW + GW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xw_en,
  input  logic          xw_idx,
  input  logic [DW-1:0] xw_data,
  input  logic          yw_en,
  input  logic          yw_idx,
  input  logic [DW-1:0] yw_data,
  input  logic [1:0]    op,
  input  logic [1:0]    x_src,
  input  logic [1:0]    y_src,
  input  logic          x_sgn,
  input  logic          y_sgn,
  input  logic          rnd_en,
  input  logic          to_fb,
  output logic [AW-1:0] acc_o,
  output logic [DW-1:0] fb_o,
  output logic          ovf_o
);
  logic [DW-1:0]        x_opnd;
  logic [DW-1:0]        y_opnd;
  logic signed [PW-1:0] prod;

  mac_operand_bank #(.DW(DW), .NREG(2)) x_bank_i (
    .clk(clk), .rst(rst), .wr_en(xw_en), .wr_idx(xw_idx), .wr_data(xw_data),
    .src(x_src), .acc_hi(acc_o[2*DW-1:DW]), .fb(fb_o), .opnd(x_opnd)
  );

  mac_operand_bank #(.DW(DW), .NREG(2)) y_bank_i (
    .clk(clk), .rst(rst), .wr_en(yw_en), .wr_idx(yw_idx), .wr_data(yw_data),
    .src(y_src), .acc_hi(acc_o[2*DW-1:DW]), .fb(fb_o), .opnd(y_opnd)
  );

  mac_multiplier #(.DW(DW)) mult_i (
    .clk(clk), .rst(rst), .a(x_opnd), .b(y_opnd), .a_sgn(x_sgn), .b_sgn(y_sgn),
    .prod(prod)
  );

  mac_accum #(.DW(DW), .GW(GW)) accum_i (
    .clk(clk), .rst(rst), .op(op), .prod(prod), .rnd_en(rnd_en), .to_fb(to_fb),
    .acc_o(acc_o), .fb_o(fb_o), .ovf_o(ovf_o)
  );

  // R10: reset clears every output
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (acc_o == '0 && fb_o == '0 && !ovf_o));
endmodule

// File: tb/mac_unit_tb_top.sv
module mac_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        xw_en = 0, xw_idx = 0, yw_en = 0, yw_idx = 0;
  logic [15:0] xw_data = 0, yw_data = 0;
  logic [1:0]  op = 0, x_src = 0, y_src = 0;
  logic        x_sgn = 0, y_sgn = 0, rnd_en = 0, to_fb = 0;
  logic [39:0] acc_o;
  logic [15:0] fb_o;
  logic        ovf_o;

  always #4 clk = ~clk;

  mac_unit dut_i (
    .clk(clk), .rst(rst), .xw_en(xw_en), .xw_idx(xw_idx), .xw_data(xw_data),
    .yw_en(yw_en), .yw_idx(yw_idx), .yw_data(yw_data), .op(op), .x_src(x_src),
    .y_src(y_src), .x_sgn(x_sgn), .y_sgn(y_sgn), .rnd_en(rnd_en), .to_fb(to_fb),
    .acc_o(acc_o), .fb_o(fb_o), .ovf_o(ovf_o)
  );

  localparam longint MASK40 = (longint'(1) << 40) - 1;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string cur_tag = "R10";

  longint m_x[2], m_y[2];
  longint m_acc = 0, m_fb = 0, m_ovf = 0;

  task automatic chk(string tag, longint act, longint exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cmp_model();
    chk(cur_tag, longint'(acc_o), m_acc, "acc");
    chk(cur_tag, longint'(fb_o), m_fb, "fb");
    chk(cur_tag, longint'(ovf_o), m_ovf, "ovf");
  endtask

  function automatic longint pick(int src, bit is_x);
    case (src)
      0: return is_x ? m_x[0] : m_y[0];
      1: return is_x ? m_x[1] : m_y[1];
      2: return (m_acc >> 16) & 16'hFFFF;
      default: return m_fb;
    endcase
  endfunction

  function automatic void model_step();
    longint xo, yo, xv, yv, p, a_s, s, r, low, rm, top;
    xo = pick(int'(x_src), 1);
    yo = pick(int'(y_src), 0);
    xv = xo; if (x_sgn && xo[15]) xv = xv - 65536;
    yv = yo; if (y_sgn && yo[15]) yv = yv - 65536;
    p = xv * yv;
    a_s = m_acc; if (m_acc[39]) a_s = a_s - (longint'(1) << 40);
    if (op != 2'b00) begin
      s = (op == 2'b01) ? p : (op == 2'b10) ? a_s + p : a_s - p;
      r = s;
      if (rnd_en) begin
        low = s & 16'hFFFF;
        r = s + 32768;
        if (low == 32768) r = r & ~(longint'(1) << 16);
      end
      rm = r & MASK40;
      top = (rm >> 31) & 9'h1FF;
      m_ovf = (top != 0 && top != 9'h1FF) ? 1 : 0;
      if (to_fb) m_fb = (rm >> 16) & 16'hFFFF;
      else m_acc = rm;
    end
    if (xw_en) m_x[xw_idx] = longint'(xw_data);
    if (yw_en) m_y[yw_idx] = longint'(yw_data);
  endfunction

  // drive one cycle at the falling edge; model compared first
  task automatic step(string tag, logic [1:0] o, logic [1:0] xs, logic [1:0] ys,
                      logic xg, logic yg, logic rn, logic fb,
                      logic xwe, logic xwi, logic [15:0] xwd,
                      logic ywe, logic ywi, logic [15:0] ywd);
    @(negedge clk);
    cmp_model();
    cur_tag = tag;
    op = o; x_src = xs; y_src = ys; x_sgn = xg; y_sgn = yg; rnd_en = rn; to_fb = fb;
    xw_en = xwe; xw_idx = xwi; xw_data = xwd;
    yw_en = ywe; yw_idx = ywi; yw_data = ywd;
    model_step();
  endtask

  task automatic wr(logic xwe, logic xwi, logic [15:0] xwd,
                    logic ywe, logic ywi, logic [15:0] ywd);
    step("R8", 2'b00, 0, 0, 0, 0, 0, 0, xwe, xwi, xwd, ywe, ywi, ywd);
  endtask

  task automatic after_edge_acc(string tag, longint exp);
    @(posedge clk); #1;
    chk(tag, longint'(acc_o), exp, "acc direct");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #1600000;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    m_x[0] = 0; m_x[1] = 0; m_y[0] = 0; m_y[1] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10: outputs cleared after reset
    chk("R10", longint'(acc_o), 0, "acc reset");
    chk("R10", longint'(fb_o), 0, "fb reset");
    chk("R10", longint'(ovf_o), 0, "ovf reset");

    // R1 R2: X0=3, Y1=-2 signed*signed -> -6
    wr(1, 0, 16'd3, 1, 1, 16'hFFFE);
    step("R1", 2'b01, 0, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    after_edge_acc("R11", 40'hFFFFFFFFFA);
    // R2: same with Y unsigned -> 3*65534
    step("R2", 2'b01, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    after_edge_acc("R2", 40'h000002FFFA);
    // R2: unsigned X with signed Y
    wr(1, 1, 16'hFFFF, 0, 0, 0);
    step("R2", 2'b01, 1, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    after_edge_acc("R2", 40'hFFFFFE0002);

    // R9: tie case 1*0x8000 rounds to even -> 0 ; 3*0x8000 -> 0x20000
    wr(1, 0, 16'd1, 1, 0, 16'h8000);
    step("R9", 2'b01, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    after_edge_acc("R9", 40'h0);
    wr(1, 0, 16'd3, 0, 0, 0);
    step("R9", 2'b01, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    after_edge_acc("R9", 40'h20000);
    // R9: non-tie 0x8001 rounds up
    wr(1, 0, 16'd1, 1, 0, 16'h8001);
    step("R9", 2'b01, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    after_edge_acc("R9", 40'h10001);

    // R4 R5: four (-32768)^2 accumulations pass 2^32, then come back
    wr(1, 0, 16'h8000, 1, 0, 16'h8000);
    step("R4", 2'b01, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++)
      step("R4", 2'b10, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    after_edge_acc("R4", 40'h0100000000);
    chk("R5", longint'(ovf_o), 1, "ovf set");
    for (int i = 0; i < 4; i++)
      step("R5", 2'b11, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    after_edge_acc("R4", 40'h0);
    chk("R5", longint'(ovf_o), 0, "ovf clear");

    // R3: hold keeps result
    step("R3", 2'b00, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    // R6 R7: result to feedback, then feed back as operands
    wr(1, 1, 16'd7, 1, 1, 16'd5);
    step("R6", 2'b01, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R6", 2'b01, 0, 0, 1, 1, 0, 1, 0, 0, 0, 0, 0, 0);
    step("R7", 2'b01, 3, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R7", 2'b10, 2, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R8: issue with X0 while rewriting X0
    step("R8", 2'b01, 0, 1, 1, 1, 0, 0, 1, 0, 16'd9, 0, 0, 0);
    step("R8", 2'b01, 0, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    after_edge_acc("R8", 40'd45);

    // random traffic, compared every cycle
    for (int i = 0; i < 2000; i++) begin
      step("R3", 2'($urandom), 2'($urandom), 2'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           16'($urandom), 1'($urandom), 1'($urandom), 16'($urandom));
    end
    step("R3", 2'b00, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    cmp_model();
    finish_run();
  end
endmodule